// File: doc/BRIEF.md
# Three-Port Buffer RAM Arbiter

This block shares one single-ported, word-addressed endpoint buffer RAM among three requesters: the CPU, the USB serial interface engine and a DMA engine. Each requester raises a request with a read/write flag, a word address and (for writes) a data word. It holds all of them steady until the arbiter answers with a one-cycle acknowledge. In any cycle the arbiter picks at most one request and drives the RAM enable, write enable, address and write data for it in that same cycle.

The choice uses a fixed two-level order. Any pending write wins over any pending read. Within writes, and within reads, the CPU comes before the serial engine, which comes before DMA. So the full order is CPU write, serial-engine write, DMA write, CPU read, serial-engine read, DMA read. The RAM answers a read one cycle after it is enabled. The arbiter passes that word back on a shared read-data bus and pulses a valid strobe only toward the requester that issued the read. A request that keeps losing just waits. There is no fairness mechanism.

Top module: `epbuf_arbiter`

## Requirements
- R1: In every cycle at most one bit of `req_ack` is high, and an acknowledged source always has its `req_valid` bit high.
- R2: When any source requests a write, the acknowledged source is a writer, regardless of which sources request reads.
- R3: Among pending writes the source with the lowest index wins: bit 0 is the CPU, bit 1 the serial engine, bit 2 DMA.
- R4: Among pending reads, when no write is pending, the same index order applies: CPU, then serial engine, then DMA.
- R5: In the acknowledge cycle `ram_en` is high and `ram_addr` carries the winner's address. For a write, `ram_we` is high and `ram_wdata` carries the winner's data, so a later read of that address returns it. For a read, `ram_we` is low.
- R6: One cycle after a read is acknowledged, `rsp_valid` pulses for exactly that source and `rsp_rdata` carries the RAM word at the read address. In all other cycles `rsp_valid` is zero.
- R7: With no request pending, `req_ack`, `ram_en` and `ram_we` are all low.
- R8: While `rst_n` is low, no acknowledge, RAM enable or response valid is produced, even if requests are present.
- R9: A losing request stays pending with no acknowledge for as long as higher-ranked requests keep arriving, and it is served in the first cycle in which it ranks highest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | N_SRC | Per-source request pending (bit 0 CPU, 1 serial engine, 2 DMA) |
| req_write | input | N_SRC | Per-source access type, 1 = write |
| req_addr | input | N_SRC*ADDR_W | Per-source word address, source i in slice i |
| req_wdata | input | N_SRC*DATA_W | Per-source write data, source i in slice i |
| req_ack | output | N_SRC | One-hot acknowledge, high in the access cycle |
| rsp_valid | output | N_SRC | One-hot read-data valid, one cycle after a read acknowledge |
| rsp_rdata | output | DATA_W | Read data shared by all sources |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W | RAM word address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_rdata | input | DATA_W | RAM read data, valid one cycle after a read enable |

## Verification
Simultaneous writes from all three sources, and then simultaneous reads, separate the per-type source order from the write-over-read rule. A mix of a low-ranked write with high-ranked reads shows that type outranks source. A write and a read to the same word raised in the same cycle show that the RAM control follows the grant and that the read sees the new data. A held DMA read facing a stream of CPU writes exposes any unwanted fairness or lost request. The end words of the address range check the address path, and a long stretch of randomly arriving requests mixes all of these cases.

// File: rtl/epbuf_arb_pkg.sv
package epbuf_arb_pkg;
   localparam int unsigned DEF_SRC   = 3;
   localparam int unsigned DEF_DEPTH = 512;
   localparam int unsigned DEF_WORD  = 32;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/epbuf_arb_pick.sv
module epbuf_arb_pick #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] valid,
   input  logic [N-1:0] write,
   output logic [N-1:0] grant,
   output logic         grant_wr
);
   logic [N-1:0] wr_req;
   logic [N-1:0] rd_req;
   logic [N-1:0] wr_pick;
   logic [N-1:0] rd_pick;

   assign wr_req = valid & write;
   assign rd_req = valid & ~write;

   // lowest index wins inside each class
   always_comb begin
      logic wr_taken;
      logic rd_taken;
      wr_taken = 1'b0;
      rd_taken = 1'b0;
      for (int i = 0; i < N; i++) begin
         wr_pick[i] = wr_req[i] & ~wr_taken;
         rd_pick[i] = rd_req[i] & ~rd_taken;
         wr_taken   = wr_taken | wr_req[i];
         rd_taken   = rd_taken | rd_req[i];
      end
   end

   assign grant_wr = |wr_req;
   assign grant    = grant_wr ? wr_pick : rd_pick;

   // R1
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));
   // R1
   grant_has_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~valid) == '0);
   // R2
   write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(valid & write)) |-> ((grant & ~write) == '0));

   for (genvar i = 1; i < N; i++) begin : g_order
      // R3
      wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (grant[i] && write[i]) |-> ((valid[i-1:0] & write[i-1:0]) == '0));
      // R4
      rd_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (grant[i] && !write[i]) |-> (valid[i-1:0] == '0 && (valid & write) == '0));
   end
endmodule

// File: rtl/epbuf_arb_mux.sv
module epbuf_arb_mux #(
   parameter int N      = 3,
   parameter int ADDR_W = 9,
   parameter int DATA_W = 32
) (
   input  logic [N-1:0]        sel,
   input  logic [N*ADDR_W-1:0] addr_in,
   input  logic [N*DATA_W-1:0] data_in,
   output logic [ADDR_W-1:0]   addr_out,
   output logic [DATA_W-1:0]   data_out
);
   logic [ADDR_W-1:0] addr_term [N];
   logic [DATA_W-1:0] data_term [N];

   for (genvar i = 0; i < N; i++) begin : g_term
      assign addr_term[i] = {ADDR_W{sel[i]}} & addr_in[i*ADDR_W +: ADDR_W];
      assign data_term[i] = {DATA_W{sel[i]}} & data_in[i*DATA_W +: DATA_W];
   end

   always_comb begin
      addr_out = '0;
      data_out = '0;
      for (int i = 0; i < N; i++) begin
         addr_out = addr_out | addr_term[i];
         data_out = data_out | data_term[i];
      end
   end
endmodule

// File: rtl/epbuf_arb_rtn.sv
module epbuf_arb_rtn #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] rd_grant,
   output logic [N-1:0] rsp_valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rsp_valid <= '0;
      else        rsp_valid <= rd_grant;
   end
endmodule

// File: rtl/epbuf_arbiter.sv
module epbuf_arbiter
   import epbuf_arb_pkg::*;
#(
   parameter  int N_SRC  = int'(DEF_SRC),
   parameter  int DEPTH  = int'(DEF_DEPTH),
   parameter  int DATA_W = int'(DEF_WORD),
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_SRC-1:0]        req_valid,
   input  logic [N_SRC-1:0]        req_write,
   input  logic [N_SRC*ADDR_W-1:0] req_addr,
   input  logic [N_SRC*DATA_W-1:0] req_wdata,
   output logic [N_SRC-1:0]        req_ack,
   output logic [N_SRC-1:0]        rsp_valid,
   output logic [DATA_W-1:0]       rsp_rdata,
   output logic                    ram_en,
   output logic                    ram_we,
   output logic [ADDR_W-1:0]       ram_addr,
   output logic [DATA_W-1:0]       ram_wdata,
   input  logic [DATA_W-1:0]       ram_rdata
);
   if (N_SRC < 1) begin : g_bad_src
      $error("N_SRC must be at least 1");
   end
   if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end

   logic [N_SRC-1:0] live_req;
   logic [N_SRC-1:0] grant;
   logic             grant_wr;
   logic [N_SRC-1:0] rd_grant;

   assign live_req = req_valid & {N_SRC{rst_n}};

   epbuf_arb_pick #(.N(N_SRC)) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (live_req),
      .write    (req_write),
      .grant    (grant),
      .grant_wr (grant_wr)
   );

   epbuf_arb_mux #(.N(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
      .sel      (grant),
      .addr_in  (req_addr),
      .data_in  (req_wdata),
      .addr_out (ram_addr),
      .data_out (ram_wdata)
   );

   assign rd_grant = grant_wr ? '0 : grant;

   epbuf_arb_rtn #(.N(N_SRC)) u_rtn (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_grant  (rd_grant),
      .rsp_valid (rsp_valid)
   );

   assign req_ack   = grant;
   assign ram_en    = |grant;
   assign ram_we    = grant_wr;
   assign rsp_rdata = ram_rdata;

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid == '0) |-> (!ram_en && !ram_we && req_ack == '0));
   // R5
   we_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> ram_en);

   for (genvar i = 0; i < N_SRC; i++) begin : g_rsp
      // R6
      rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (req_ack[i] && !req_write[i]) |=> rsp_valid[i]);
      // R6
      rsp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid[i] |-> $past(req_ack[i] && !req_write[i] && ram_en && !ram_we));
   end
endmodule

// File: tb/epbuf_arbiter_tb.sv
module epbuf_arbiter_tb;
   localparam int NS = 3;
   localparam int AW = 9;
   localparam int DW = 32;
   localparam int WORDS = 512;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NS-1:0]    req_valid = '0;
   logic [NS-1:0]    req_write = '0;
   logic [NS*AW-1:0] req_addr  = '0;
   logic [NS*DW-1:0] req_wdata = '0;
   logic [NS-1:0]    req_ack;
   logic [NS-1:0]    rsp_valid;
   logic [DW-1:0]    rsp_rdata;
   logic             ram_en;
   logic             ram_we;
   logic [AW-1:0]    ram_addr;
   logic [DW-1:0]    ram_wdata;
   logic [DW-1:0]    ram_rdata;

   always #5 clk = ~clk;

   epbuf_arbiter u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ack(req_ack), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
   );

   // bench-side RAM
   logic [DW-1:0] mem [WORDS];
   always @(posedge clk) begin
      if (ram_en) begin
         if (ram_we) mem[ram_addr] <= ram_wdata;
         else        ram_rdata     <= mem[ram_addr];
      end
   end

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   // requester model and shadow memory
   logic          pv [NS];
   logic          pw [NS];
   logic [AW-1:0] pa [NS];
   logic [DW-1:0] pd [NS];
   logic [DW-1:0] shadow [WORDS];

   typedef struct { int src; logic [DW-1:0] data; int stamp; } rsp_t;
   rsp_t exp_q [$];

   task automatic req(input int s, input bit w, input int a, input logic [DW-1:0] d);
      pv[s] = 1'b1; pw[s] = w; pa[s] = AW'(a); pd[s] = d;
   endtask

   task automatic step(input string tag);
      int w;
      rsp_t it;
      @(negedge clk);
      for (int i = 0; i < NS; i++) begin
         req_valid[i] = pv[i];
         req_write[i] = pw[i];
         req_addr[i*AW +: AW] = pa[i];
         req_wdata[i*DW +: DW] = pd[i];
      end
      #2;
      w = -1;
      for (int i = 0; i < NS; i++) if (w < 0 && pv[i] && pw[i]) w = i;
      for (int i = 0; i < NS; i++) if (w < 0 && pv[i] && !pw[i]) w = i;
      // R1 plus the scenario's ordering rule
      chk(req_ack == ((w < 0) ? 3'b000 : 3'(1 << w)), tag, 64'(req_ack),
          (w < 0) ? 64'd0 : 64'(1 << w));
      if (w < 0) begin
         // R7
         chk(!ram_en && !ram_we, "R7", {62'd0, ram_en, ram_we}, 64'd0);
      end else if (pw[w]) begin
         // R5
         chk(ram_en && ram_we && ram_addr == pa[w] && ram_wdata == pd[w], "R5",
             {ram_en, ram_we, 21'd0, ram_addr, ram_wdata}, {2'b11, 21'd0, pa[w], pd[w]});
         shadow[pa[w]] = pd[w];
      end else begin
         // R5
         chk(ram_en && !ram_we && ram_addr == pa[w], "R5",
             {ram_en, ram_we, 53'd0, ram_addr}, {2'b10, 53'd0, pa[w]});
         it.src = w; it.data = shadow[pa[w]]; it.stamp = cyc;
         exp_q.push_back(it);
      end
      if (w >= 0) pv[w] = 1'b0;
   endtask

   task automatic drain(input string tag);
      for (int k = 0; k < 20; k++) begin
         if (!pv[0] && !pv[1] && !pv[2]) break;
         step(tag);
      end
   endtask

   // monitor: scoreboard for read returns (R6)
   bit mon_on = 1'b0;
   always @(negedge clk) begin
      rsp_t it;
      #3;
      if (mon_on) begin
         if (exp_q.size() > 0 && exp_q[0].stamp < cyc) begin
            it = exp_q.pop_front();
            chk(rsp_valid == 3'(1 << it.src) && rsp_rdata == it.data, "R6",
                {29'd0, rsp_valid, rsp_rdata}, {29'd0, 3'(1 << it.src), it.data});
         end else begin
            chk(rsp_valid == '0, "R6", 64'(rsp_valid), 64'd0);
         end
      end
   end

   // watchdog
   bit done = 1'b0;
   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < WORDS; i++) begin mem[i] = '0; shadow[i] = '0; end
      for (int i = 0; i < NS; i++) begin pv[i] = 0; pw[i] = 0; pa[i] = '0; pd[i] = '0; end
      ram_rdata = '0;

      // R8: requests during reset get no service
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         req_valid = 3'b111; req_write = 3'b010;
         #2;
         chk(req_ack == '0 && !ram_en && rsp_valid == '0, "R8",
             {58'd0, req_ack, ram_en, rsp_valid[1:0]}, 64'd0);
      end
      @(negedge clk);
      req_valid = '0; req_write = '0;
      rst_n = 1'b1;
      mon_on = 1'b1;

      // R7: idle
      step("R7"); step("R7");

      // R3: three writes at once -> CPU, SIE, DMA
      req(0, 1, 10, 32'hC0C0_0001);
      req(1, 1, 11, 32'h5E5E_0002);
      req(2, 1, 12, 32'hD0D0_0003);
      drain("R3");

      // R4: three reads at once -> CPU, SIE, DMA, data returned
      req(0, 0, 12, '0);
      req(1, 0, 10, '0);
      req(2, 0, 11, '0);
      drain("R4");
      step("R6");

      // R2: low-ranked write beats high-ranked reads
      req(0, 0, 11, '0);
      req(1, 0, 12, '0);
      req(2, 1, 13, 32'hAAAA_5555);
      drain("R2");

      // R5: write and read of same word raised together
      req(1, 1, 5, 32'h1234_5678);
      req(0, 0, 5, '0);
      drain("R5");

      // boundary addresses R5
      req(2, 1, 0, 32'h0000_F00D);
      req(0, 1, WORDS - 1, 32'hFFFF_BEEF);
      drain("R3");
      req(2, 0, WORDS - 1, '0);
      req(1, 0, 0, '0);
      drain("R4");
      step("R6");

      // R9: DMA read waits behind a stream of CPU writes
      req(2, 0, 13, '0);
      for (int k = 0; k < 8; k++) begin
         req(0, 1, 100 + k, 32'(k * 7 + 1));
         step("R9");
      end
      drain("R9");
      step("R6");

      // mixed random traffic R1
      for (int k = 0; k < 2000; k++) begin
         for (int s = 0; s < NS; s++) begin
            if (!pv[s] && ($urandom % 3 != 0))
               req(s, 1'($urandom), int'($urandom % WORDS), $urandom);
         end
         step("R1");
      end
      drain("R1");
      repeat (3) step("R7");

      chk(exp_q.size() == 0, "R6", 64'(exp_q.size()), 64'd0);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule